// File: doc/BRIEF.md
# Staged-Update DDS Command Controller

This block is a direct digital synthesizer whose settings reach the signal path only through a two-level register set. A host sends command words on a valid/ready handshake. Each word carries a 4-bit opcode and a 32-bit payload. The opcode either writes a shadow register (tuning word, phase offset or amplitude) or stages a request to zero the phase accumulator.

Shadow writes do not disturb the output. Any command whose commit flag is set copies the complete shadow set into the active registers on a single clock edge. The same copy includes the value that command carries, and it fires any staged accumulator clear. Frequency, phase and amplitude therefore change together, and no mixed state ever reaches the output.

The active values drive the signal path. It consists of a 32-bit wrapping phase accumulator, a phase-offset adder, and a sine table computed at elaboration. A signed amplitude scaler follows the table. The result is one 16-bit signed sample per clock, produced by a fixed 3-stage pipeline.

Top module: `dds_stage_ctrl`

## Requirements
- R1: While rst_ni is low, every shadow, active, pending and pipeline register is zero, so smp_o reads 0. cmd_ready_o is high at all times.
- R2: cmd_op_i[2:0] selects the operation: 0 writes the phase offset, 1 stages an accumulator clear, 2 writes the tuning word and 3 writes the amplitude from cmd_data_i[15:0]. Values 4 to 7 write nothing.
- R3: A command with cmd_op_i[3] low only changes shadow state. smp_o keeps following the previously active settings.
- R4: A command with cmd_op_i[3] high makes the tuning word, phase offset and amplitude active on the same edge. The active values are the shadow values as updated by that command's own write.
- R5: A command whose low opcode bits are 4 to 7 still commits when cmd_op_i[3] is high.
- R6: A staged clear stays pending across later commands until a commit. On the commit edge the accumulator becomes 0. From the next edge on, the new tuning word is added each cycle. A commit clears the pending request.
- R7: The accumulator adds the active tuning word every cycle, modulo 2^32. A tuning word with bit 31 set makes the phase run backwards.
- R8: The top 10 bits of (accumulator + phase offset) mod 2^32 index a sine table. Table entry k is round(32767*sin(2*pi*k/1024)).
- R9: smp_o = floor((sample*amplitude + 2^14) / 2^15), where sample and amplitude are signed 16-bit values. The result is saturated to the signed 16-bit range.
- R10: smp_o, sampled after clock edge n+3, is computed from the accumulator, phase offset and amplitude that hold after edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command word present |
| cmd_ready_o | output | 1 | Command accepted (always high) |
| cmd_op_i | input | 4 | Bit 3: commit flag; bits 2:0: operation |
| cmd_data_i | input | 32 | Command payload |
| smp_o | output | 16 | Signed output sample |

## Verification
The assertions check several behaviours on every cycle:
- the active registers hold still whenever no commit is accepted, and match the shadow set right after one;
- a commit clears the pending clear request;
- a fired clear leaves the accumulator at zero, and the next cycle it equals the active tuning word;
- a zero sample or zero amplitude gives a zero output.

Other behaviours only appear through the bench's scenarios. These are the sine contents, the rounding of the product, and the 3-cycle alignment of the output with the settings. Others are a staged clear that survives several uncommitted writes, the commit carried by an unknown opcode, and wrap-around in both directions. The bench checks these by comparing smp_o with a reference model on every cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [2:0] {
    OP_PHASE = 3'd0,
    OP_CLEAR = 3'd1,
    OP_TUNE  = 3'd2,
    OP_AMPL  = 3'd3
  } dds_op_e;

  localparam longint PI_Q30 = 64'sd3373259426;  // pi * 2^30

  // round((2^(sw-1)-1) * sin(2*pi*idx/2^aw)), integer series on a folded quarter wave
  function automatic int sine_entry(int idx, int aw, int sw);
    longint half, quarter, k, x, x2, term, acc, peak, v;
    bit     neg;
    quarter = longint'(1) << (aw - 2);
    half    = quarter * 2;
    neg     = (longint'(idx) >= half);
    k       = longint'(idx) % half;
    if (k > quarter) k = half - k;
    x    = (k * PI_Q30) / half;
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int n = 1; n <= 8; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    peak = (longint'(1) << (sw - 1)) - 1;
    v    = (acc * peak + (longint'(1) << 29)) >>> 30;
    return neg ? -int'(v) : int'(v);
  endfunction

endpackage

// File: rtl/dds_shadow_regs.sv
module dds_shadow_regs
  import dds_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMP_W  = 16,
  parameter int OP_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [OP_W-1:0]         op_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W-1:0]       act_tune_o,
  output logic [DATA_W-1:0]       act_phase_o,
  output logic signed [AMP_W-1:0] act_amp_o,
  output logic                    acc_clr_o
);

  localparam int COMMIT_BIT = OP_W - 1;

  logic [DATA_W-1:0]       sh_tune_q, sh_phase_q, sh_tune_d, sh_phase_d;
  logic signed [AMP_W-1:0] sh_amp_q, sh_amp_d;
  logic                    pend_q, pend_d, commit;

  assign commit = valid_i & op_i[COMMIT_BIT];

  always_comb begin
    sh_tune_d  = sh_tune_q;
    sh_phase_d = sh_phase_q;
    sh_amp_d   = sh_amp_q;
    pend_d     = pend_q;
    if (valid_i) begin
      case (op_i[COMMIT_BIT-1:0])
        OP_PHASE: sh_phase_d = data_i;
        OP_CLEAR: pend_d     = 1'b1;
        OP_TUNE:  sh_tune_d  = data_i;
        OP_AMPL:  sh_amp_d   = AMP_W'(data_i);
        default:  ;
      endcase
    end
  end

  assign acc_clr_o = commit & pend_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_tune_q   <= '0;
      sh_phase_q  <= '0;
      sh_amp_q    <= '0;
      pend_q      <= 1'b0;
      act_tune_o  <= '0;
      act_phase_o <= '0;
      act_amp_o   <= '0;
    end else begin
      sh_tune_q  <= sh_tune_d;
      sh_phase_q <= sh_phase_d;
      sh_amp_q   <= sh_amp_d;
      pend_q     <= commit ? 1'b0 : pend_d;
      if (commit) begin
        act_tune_o  <= sh_tune_d;
        act_phase_o <= sh_phase_d;
        act_amp_o   <= sh_amp_d;
      end
    end
  end

  assert_active_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> ($stable(act_tune_o) && $stable(act_phase_o) && $stable(act_amp_o)));

  assert_commit_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (act_tune_o == sh_tune_q && act_phase_o == sh_phase_q && act_amp_o == sh_amp_q));

  assert_pending_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !pend_q);

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int LUT_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [ACC_W-1:0]  tune_i,
  input  logic [ACC_W-1:0]  phase_i,
  output logic [LUT_AW-1:0] idx_o
);

  localparam int SHIFT = ACC_W - LUT_AW;

  logic [ACC_W-1:0] acc_q, sum_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_q + tune_i;  // wraps mod 2^ACC_W
  end

  assign sum_w = acc_q + phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_o <= '0;
    else         idx_o <= LUT_AW'(sum_w >> SHIFT);
  end

  assert_clear_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));

  assert_restart_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && !clr_i) |=> (acc_q == $past(tune_i)));

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
  import dds_pkg::*;
#(
  parameter int LUT_AW = 10,
  parameter int SMP_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LUT_AW-1:0]       idx_i,
  output logic signed [SMP_W-1:0] smp_o
);

  localparam int DEPTH = 1 << LUT_AW;

  logic signed [SMP_W-1:0] lut [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lut
    localparam int VAL = sine_entry(g, LUT_AW, SMP_W);
    assign lut[g] = SMP_W'(VAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_o <= '0;
    else         smp_o <= lut[idx_i];
  end

endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
  parameter int SMP_W = 16,
  parameter int AMP_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [AMP_W-1:0] amp_i,
  output logic signed [SMP_W-1:0] out_o
);

  localparam int PROD_W = SMP_W + AMP_W;
  localparam int FRAC   = AMP_W - 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (FRAC - 1);
  localparam logic signed [PROD_W-1:0] MAXV = (PROD_W'(1) <<< (SMP_W - 1)) - 1;
  localparam logic signed [PROD_W-1:0] MINV = -(PROD_W'(1) <<< (SMP_W - 1));

  logic signed [PROD_W-1:0] prod, rnd;
  logic signed [SMP_W-1:0]  sat;

  always_comb begin
    prod = PROD_W'(smp_i) * PROD_W'(amp_i);
    rnd  = (prod + HALF) >>> FRAC;
    if (rnd > MAXV)      sat = SMP_W'(MAXV);
    else if (rnd < MINV) sat = SMP_W'(MINV);
    else                 sat = SMP_W'(rnd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= '0;
    else         out_o <= sat;
  end

  assert_zero_in_zero_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i == '0 || amp_i == '0) |=> (out_o == '0));

endmodule

// File: rtl/dds_stage_ctrl.sv
module dds_stage_ctrl #(
  parameter int ACC_W  = 32,
  parameter int LUT_AW = 10,
  parameter int SMP_W  = 16,
  parameter int AMP_W  = 16,
  parameter int OP_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [OP_W-1:0]  cmd_op_i,
  input  logic [ACC_W-1:0] cmd_data_i,
  output logic [SMP_W-1:0] smp_o
);

  logic [ACC_W-1:0]        act_tune, act_phase;
  logic signed [AMP_W-1:0] act_amp, amp_s1, amp_s2;
  logic                    acc_clr;
  logic [LUT_AW-1:0]       idx_s1;
  logic signed [SMP_W-1:0] sine_s2, out_s3;

  assign cmd_ready_o = 1'b1;

  dds_shadow_regs #(.DATA_W(ACC_W), .AMP_W(AMP_W), .OP_W(OP_W)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (cmd_valid_i),
    .op_i        (cmd_op_i),
    .data_i      (cmd_data_i),
    .act_tune_o  (act_tune),
    .act_phase_o (act_phase),
    .act_amp_o   (act_amp),
    .acc_clr_o   (acc_clr)
  );

  dds_phase_acc #(.ACC_W(ACC_W), .LUT_AW(LUT_AW)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (acc_clr),
    .tune_i  (act_tune),
    .phase_i (act_phase),
    .idx_o   (idx_s1)
  );

  dds_sine_rom #(.LUT_AW(LUT_AW), .SMP_W(SMP_W)) u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (idx_s1),
    .smp_o  (sine_s2)
  );

  // amplitude travels beside the phase so all three settings line up at the multiplier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_s1 <= '0;
      amp_s2 <= '0;
    end else begin
      amp_s1 <= act_amp;
      amp_s2 <= amp_s1;
    end
  end

  dds_amp_scale #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .smp_i  (sine_s2),
    .amp_i  (amp_s2),
    .out_o  (out_s3)
  );

  assign smp_o = out_s3;

  assert_ready_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> cmd_ready_o);

endmodule

// File: tb/dds_stage_ctrl_bench.sv
`timescale 1ns/1ps
module dds_stage_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready;
  logic [15:0] smp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dds_stage_ctrl u_dds_stage_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_op_i    (cmd_op),
    .cmd_data_i  (cmd_data),
    .smp_o       (smp)
  );

  // reference model state, values after the latest edge
  logic [31:0] m_sh_tune, m_sh_phase, m_tune, m_phase, m_acc;
  logic [15:0] m_sh_amp, m_amp;
  bit          m_pend;
  int          exp_q[$];
  bit          exact_q[$];

  function automatic int ref_sine(int k);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(k) / 1024.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int ref_scale(int s, int a);
    longint p;
    int     v;
    p = (longint'(s) * longint'(a) + 16384) >>> 15;
    v = int'(p);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh_tune = '0; m_sh_phase = '0; m_sh_amp = '0; m_pend = 1'b0;
      m_tune = '0; m_phase = '0; m_amp = '0; m_acc = '0;
      exp_q.delete();
      exact_q.delete();
    end else begin
      logic [31:0] idx_full;
      bit clr;
      clr = 1'b0;
      if (cmd_valid) begin
        case (cmd_op[2:0])
          3'd0: m_sh_phase = cmd_data;
          3'd1: m_pend = 1'b1;
          3'd2: m_sh_tune = cmd_data;
          3'd3: m_sh_amp = cmd_data[15:0];
          default: ;
        endcase
      end
      if (cmd_valid && cmd_op[3]) begin
        clr = m_pend;
        m_pend = 1'b0;
      end
      m_acc = clr ? 32'd0 : m_acc + m_tune;
      if (cmd_valid && cmd_op[3]) begin
        m_tune = m_sh_tune; m_phase = m_sh_phase; m_amp = m_sh_amp;
      end
      idx_full = (m_acc + m_phase) >> 22;
      exp_q.push_back(ref_scale(ref_sine(int'(idx_full)), int'($signed(m_amp))));
      exact_q.push_back((idx_full % 256) == 0);
    end
  end

  // scoreboard monitor: compare each cycle against the item pushed three edges earlier (R8 R9 R10)
  always @(negedge clk) begin
    if (rst_n && exp_q.size() == 4 && !done) begin
      int e, a, d;
      bit x;
      e = exp_q.pop_front();
      x = exact_q.pop_front();
      a = int'($signed(smp));
      d = (a > e) ? a - e : e - a;
      checks++;
      if ((x && d != 0) || d > 2) begin
        errors++;
        $display("FAIL R10 stream: smp_o=%0d expected %0d", a, e);
      end
    end
  end

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // drive at a falling edge, accepted at the next rising edge, return at the following falling edge
  task automatic send(logic [3:0] op, logic [31:0] data);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = '0;
    cmd_data  = '0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check("R1 reset out", int'($signed(smp)), 0);
    check("R1 ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1 after reset", int'($signed(smp)), 0);

    // amplitude full scale, index 0
    send(4'hB, 32'h0000_7FFF);
    wait_cyc(3);
    check("R8 index 0", int'($signed(smp)), 0);

    // staged phase only
    send(4'h0, 32'h4000_0000);
    wait_cyc(6);
    check("R3 staged phase held", int'($signed(smp)), 0);
    check("R1 ready busy", int'(cmd_ready), 1);
    send(4'hB, 32'h0000_4000);
    wait_cyc(3);
    check("R4 phase+amp commit", int'($signed(smp)), 16384);

    // stage two values, commit via tuning write
    send(4'h0, 32'hC000_0000);
    send(4'h3, 32'h0000_8001);
    wait_cyc(4);
    check("R3 staged pair held", int'($signed(smp)), 16384);
    send(4'hA, 32'h0000_0000);
    wait_cyc(3);
    check("R9 neg times neg", int'($signed(smp)), 32766);

    // staged clear fired with new tuning word
    send(4'h1, 32'h0000_0001);
    wait_cyc(3);
    send(4'hA, 32'h0100_0000);
    wait_cyc(3);
    check("R6 clear on commit", int'($signed(smp)), 32766);
    wait_cyc(40);

    // clear stays pending across uncommitted writes
    send(4'h1, 32'h0000_0001);
    send(4'h2, 32'h0100_0000);
    wait_cyc(20);
    send(4'h8, 32'h4000_0000);
    wait_cyc(3);
    check("R6 pending clear", int'($signed(smp)), -32766);
    check("R2 op0 phase", int'($signed(smp)), -32766);

    // unknown ops: no write, commit honoured
    send(4'h2, 32'h0000_0000);
    send(4'h3, 32'h0000_7FFF);
    send(4'h1, 32'h0000_0001);
    send(4'hC, 32'h1234_5678);
    wait_cyc(3);
    check("R5 unknown op commits", int'($signed(smp)), 32766);
    send(4'h5, 32'hFFFF_FFFF);
    send(4'hF, 32'h0000_0000);
    wait_cyc(8);
    check("R2 unknown op writes nothing", int'($signed(smp)), 32766);

    // backwards phase: 256 steps of -2^22 land on index 768
    send(4'h0, 32'h0000_0000);
    send(4'h1, 32'h0000_0001);
    send(4'hA, 32'hFFC0_0000);
    wait_cyc(259);
    check("R7 negative tuning", int'($signed(smp)), -32766);

    // forward with wrap: 1280 steps of 2^22 land on index 256
    send(4'h1, 32'h0000_0001);
    send(4'hA, 32'h0040_0000);
    wait_cyc(1283);
    check("R7 wrap forward", int'($signed(smp)), 32766);
    wait_cyc(100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule